// File: doc/BRIEF.md
# Two-Way Set-Associative Word Cache with LRU Replacement

This block sits between a single requester and a word-addressed backing memory and keeps a small number of recently used words close at hand. Each cache entry holds exactly one word. The low bits of the word address select a set. The remaining upper bits form a tag, and that tag is compared against both entries (ways) of the selected set. Each way keeps a valid flag, a tag and a data word. Each set keeps one bit that names the way to evict next.

The requester issues one request at a time over a valid/ready handshake and receives a one-cycle response pulse. The response carries the word and a flag that says whether the access hit. Reads that miss fetch the word over a request/acknowledge memory port and install it before they respond.

Writes always go through to memory. A write that misses also installs the word in the cache. Two free-running counters record hits and misses.

Top module: `assoc2_cache`

## Requirements
- R1: After synchronous reset `req_ready` is 1, `rsp_valid` and `mem_req` are 0, both counters read 0, and every set is empty, so the first access to any address misses.
- R2: An access hits only when a way of the selected set is valid and its stored tag equals the upper address bits. A read hit responds with the cached word and `rsp_hit`=1 and issues no memory transaction.
- R3: Address bits [SET_BITS-1:0] select the set. Addresses in different sets never evict each other, and addresses with the same set bits but different upper bits do not hit each other.
- R4: On a miss the word is installed in the lowest-numbered invalid way of the set if one exists.
- R5: On a miss in a set whose two ways are both valid, the way recorded as least recently used is replaced.
- R6: Every access marks the way it touched as most recently used. This includes read hits, write hits, read fills and write allocations.
- R7: With default parameters (two sets, four words), the read sequence 0, 2, 0, 1, 4, 0 yields miss, miss, hit, miss, miss, hit. In that sequence, 4 displaces 2.
- R8: From reset with default parameters, the read sequence 0, 2, 0, 4, 2 yields miss, miss, hit, miss, miss.
- R9: Every write issues one memory write with its address and data. `mem_req` is held, with a stable address, until `mem_ack`. A write hit updates the cached word, so a later read hit returns the new data.
- R10: A write miss installs the written word (write-allocate), so a following read of that address hits without a memory transaction.
- R11: `hit_count` increments by one for each hit and `miss_count` increments by one for each miss. Neither counter changes in any other way.
- R12: A read miss responds with `rsp_hit`=0 and the word returned by memory on `mem_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | The access hit in the cache |
| rsp_rdata | output | DATA_W | Read data (the written word for writes) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory completes the request |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |
| hit_count | output | CNT_W | Number of hits since reset |
| miss_count | output | CNT_W | Number of misses since reset |

## Verification
The stored tags and valid flags show at the ports only through `rsp_hit` and through whether a memory read appears. A corrupted tag or valid flag therefore shows on the next access to that set. A wrong LRU bit is less visible: it stays hidden until the set is full and a third tag arrives. For that reason the replacement sequences revisit the survivor right after each eviction, which exposes a wrong victim within one or two accesses. Wrong cached data shows only on a read hit, so each write is followed at once by a read of the same address.

// File: rtl/assoc2_pkg.sv
package assoc2_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_MEM  = 2'd2
    } ctl_state_e;

    // way to fill on a miss: first empty way, else the recorded LRU way
    function automatic logic pick_victim(input logic v0, input logic v1, input logic lru_way);
        if (!v0)      return 1'b0;
        else if (!v1) return 1'b1;
        else          return lru_way;
    endfunction

endpackage

// File: rtl/cache_way_bank.sv
module cache_way_bank #(
    parameter int SETS   = 2,
    parameter int TAG_W  = 7,
    parameter int DATA_W = 32,
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  set_sel,
    output logic              ent_valid,
    output logic [TAG_W-1:0]  ent_tag,
    output logic [DATA_W-1:0] ent_data,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];

    always_ff @(posedge clk) begin
        if (rst)        valid_q <= '0;
        else if (wr_en) valid_q[set_sel] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[set_sel]  <= wr_tag;
            data_q[set_sel] <= wr_data;
        end
    end

    assign ent_valid = valid_q[set_sel];
    assign ent_tag   = tag_q[set_sel];
    assign ent_data  = data_q[set_sel];
endmodule

// File: rtl/cache_lru_bank.sv
module cache_lru_bank #(
    parameter int SETS = 2,
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_set,
    output logic             evict_way,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_set,
    input  logic             touch_way
);
    // each bit names the way to evict next in its set
    logic [SETS-1:0] lru_q;

    always_ff @(posedge clk) begin
        if (rst)        lru_q <= '0;
        else if (touch) lru_q[touch_set] <= ~touch_way;
    end

    assign evict_way = lru_q[rd_set];

    // R6
    touch_makes_mru_chk: assert property (@(posedge clk) disable iff (rst)
        touch |=> (lru_q[$past(touch_set)] != $past(touch_way)));
endmodule

// File: rtl/assoc2_cache.sv
module assoc2_cache
    import assoc2_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int SET_BITS = 1,
    parameter int CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    localparam int SETS  = 1 << SET_BITS;
    localparam int TAG_W = ADDR_W - SET_BITS;
    localparam int WAYS  = 2;

    ctl_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              wr_q, hit_q, vic_q;

    logic [SET_BITS-1:0] set_idx;
    logic [TAG_W-1:0]    tag_cur;
    assign set_idx = addr_q[SET_BITS-1:0];
    assign tag_cur = addr_q[ADDR_W-1:SET_BITS];

    logic [WAYS-1:0]   way_valid, hit_vec, way_we;
    logic [TAG_W-1:0]  way_tag  [WAYS];
    logic [DATA_W-1:0] way_data [WAYS];
    logic [DATA_W-1:0] fill_data;

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        cache_way_bank #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_bank (
            .clk       (clk),
            .rst       (rst),
            .set_sel   (set_idx),
            .ent_valid (way_valid[g]),
            .ent_tag   (way_tag[g]),
            .ent_data  (way_data[g]),
            .wr_en     (way_we[g]),
            .wr_tag    (tag_cur),
            .wr_data   (fill_data)
        );
        assign hit_vec[g] = way_valid[g] && (way_tag[g] == tag_cur);
    end

    logic lru_way, touch, touch_way;
    cache_lru_bank #(.SETS(SETS)) u_lru (
        .clk       (clk),
        .rst       (rst),
        .rd_set    (set_idx),
        .evict_way (lru_way),
        .touch     (touch),
        .touch_set (set_idx),
        .touch_way (touch_way)
    );

    logic hit_any, hit_way, victim;
    assign hit_any = |hit_vec;
    assign hit_way = hit_vec[1];
    assign victim  = pick_victim(way_valid[0], way_valid[1], lru_way);

    // array and LRU update decisions
    always_comb begin
        way_we    = '0;
        fill_data = wdata_q;
        touch     = 1'b0;
        touch_way = 1'b0;
        if (state_q == ST_LOOK) begin
            if (hit_any) begin
                touch     = 1'b1;
                touch_way = hit_way;
                if (wr_q) way_we[hit_way] = 1'b1;
            end else if (wr_q) begin
                touch          = 1'b1;
                touch_way      = victim;
                way_we[victim] = 1'b1;
            end
        end else if (state_q == ST_MEM && mem_ack && !wr_q) begin
            fill_data     = mem_rdata;
            touch         = 1'b1;
            touch_way     = vic_q;
            way_we[vic_q] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            addr_q     <= '0;
            wdata_q    <= '0;
            wr_q       <= 1'b0;
            hit_q      <= 1'b0;
            vic_q      <= 1'b0;
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_rdata  <= '0;
            mem_req    <= 1'b0;
            hit_count  <= '0;
            miss_count <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                    wr_q    <= req_write;
                    state_q <= ST_LOOK;
                end
                ST_LOOK: begin
                    hit_q <= hit_any;
                    vic_q <= victim;
                    if (hit_any) hit_count  <= hit_count + 1'b1;
                    else         miss_count <= miss_count + 1'b1;
                    if (hit_any && !wr_q) begin
                        rsp_valid <= 1'b1;
                        rsp_hit   <= 1'b1;
                        rsp_rdata <= way_data[hit_way];
                        state_q   <= ST_IDLE;
                    end else begin
                        mem_req <= 1'b1;
                        state_q <= ST_MEM;
                    end
                end
                ST_MEM: if (mem_ack) begin
                    mem_req   <= 1'b0;
                    rsp_valid <= 1'b1;
                    rsp_hit   <= hit_q;
                    rsp_rdata <= wr_q ? wdata_q : mem_rdata;
                    state_q   <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign mem_write = wr_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;

    // R2
    single_match_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOOK) |-> $onehot0(hit_vec));
    // R2
    hit_read_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit && !wr_q) |-> !mem_req);
    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_write)));
    // R11
    hit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_count != $past(hit_count)) |-> (hit_count == $past(hit_count) + 1'b1));
    // R11
    miss_step_chk: assert property (@(posedge clk) disable iff (rst)
        (miss_count != $past(miss_count)) |-> (miss_count == $past(miss_count) + 1'b1));
endmodule

// File: tb/assoc2_cache_test.sv
module assoc2_cache_test;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid, rsp_hit;
    logic [DW-1:0] rsp_rdata;
    logic          mem_req, mem_write;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic [CW-1:0] hit_count, miss_count;

    assoc2_cache uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
        .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int mem_ops = 0;
    logic [DW-1:0] mem [256];

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // backing memory: acknowledges one cycle after a request appears
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 + i * 32'h101;
        forever begin
            @(posedge clk);
            if (mem_req && !mem_ack) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem[mem_addr];
                if (mem_write) mem[mem_addr] = mem_wdata;
                mem_ops++;
            end else begin
                mem_ack <= 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic access(input bit wr, input int addr, input logic [DW-1:0] d,
                          input bit exp_hit, input string req);
        int ops0;
        int n;
        logic [DW-1:0] exp_data;
        exp_data = wr ? d : mem[addr];
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        ops0 = mem_ops;
        req_valid = 1'b1; req_write = wr; req_addr = AW'(addr); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 50) begin @(negedge clk); n++; end
        chk(rsp_valid, req, $sformatf("response for addr %0d", addr), DW'(rsp_valid), 1);
        chk(rsp_hit == exp_hit, req, $sformatf("hit flag addr %0d", addr), DW'(rsp_hit), DW'(exp_hit));
        if (!wr) begin
            chk(rsp_rdata == exp_data, req, $sformatf("read data addr %0d", addr), rsp_rdata, exp_data);
            if (exp_hit)
                chk(mem_ops == ops0, req, "memory ops on read hit", DW'(mem_ops - ops0), 0);
        end else begin
            chk(mem[addr] == d, req, $sformatf("memory after write addr %0d", addr), mem[addr], d);
        end
    endtask

    task automatic chk_counts(input int h, input int m, input string req);
        chk(hit_count == CW'(h), req, "hit_count", DW'(hit_count), DW'(h));
        chk(miss_count == CW'(m), req, "miss_count", DW'(miss_count), DW'(m));
    endtask

    // R1 reset state
    task automatic t_reset();
        do_reset();
        chk(req_ready == 1'b1, "R1", "req_ready", DW'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", DW'(rsp_valid), 0);
        chk(mem_req == 1'b0, "R1", "mem_req", DW'(mem_req), 0);
        chk_counts(0, 0, "R1");
        access(0, 9, '0, 0, "R1");
    endtask

    // R7 with R4 (empty ways filled first) and R5 (LRU victim), then R11
    task automatic t_seq_a();
        do_reset();
        access(0, 0, '0, 0, "R7");
        access(0, 2, '0, 0, "R4");
        access(0, 0, '0, 1, "R7");
        access(0, 1, '0, 0, "R7");
        access(0, 4, '0, 0, "R5");
        access(0, 0, '0, 1, "R7");
        access(0, 2, '0, 0, "R5");
        access(0, 0, '0, 1, "R5");
        chk_counts(3, 5, "R11");
    endtask

    // R8 and continuation showing the LRU moves
    task automatic t_seq_b();
        do_reset();
        access(0, 0, '0, 0, "R8");
        access(0, 2, '0, 0, "R8");
        access(0, 0, '0, 1, "R8");
        access(0, 4, '0, 0, "R8");
        access(0, 2, '0, 0, "R8");
        access(0, 4, '0, 1, "R5");
        access(0, 0, '0, 0, "R5");
        chk_counts(2, 5, "R11");
    endtask

    // R3 set independence and tag compare
    task automatic t_sets();
        do_reset();
        access(0, 1, '0, 0, "R3");
        access(0, 3, '0, 0, "R3");
        access(0, 0, '0, 0, "R3");
        access(0, 2, '0, 0, "R3");
        access(0, 1, '0, 1, "R3");
        access(0, 3, '0, 1, "R3");
        access(0, 0, '0, 1, "R3");
        access(0, 2, '0, 1, "R3");
        access(0, 128, '0, 0, "R3");
        access(0, 2, '0, 1, "R3");
    endtask

    // R9, R10, R12 write-through with allocation
    task automatic t_writes();
        do_reset();
        access(1, 6, 32'h1234_5678, 0, "R10");
        access(0, 6, '0, 1, "R10");
        access(1, 6, 32'hDEAD_BEEF, 1, "R9");
        access(0, 6, '0, 1, "R9");
        chk(rsp_rdata == 32'hDEAD_BEEF, "R9", "updated cached word", rsp_rdata, 32'hDEAD_BEEF);
        access(0, 7, '0, 0, "R12");
        chk_counts(3, 2, "R11");
    endtask

    // R6 a write hit refreshes recency
    task automatic t_touch();
        do_reset();
        access(0, 0, '0, 0, "R6");
        access(0, 2, '0, 0, "R6");
        access(1, 0, 32'h0F0F_0F0F, 1, "R6");
        access(0, 4, '0, 0, "R6");
        access(0, 0, '0, 1, "R6");
        access(0, 2, '0, 0, "R6");
    endtask

    initial begin
        t_reset();
        t_seq_a();
        t_seq_b();
        t_sets();
        t_writes();
        t_touch();
        report();
    end
endmodule